// File: doc/BRIEF.md
# Event Sequence Trigger

This block watches a stream of four boolean event flags, one set per valid sample, and raises a trigger when a programmed pattern in the style of a regular expression has been seen. The pattern is a chain of up to four stages. Each stage names the set of events that satisfy it, so any one of them will do. This gives alternation. The stages are visited in order, which gives concatenation. Each stage also holds a lower and an upper repetition bound, and a flag can lift the upper bound. With these a stage can express an exact count, a bounded range, one-or-more, zero-or-more or an optional step.

Software writes each stage's settings through a simple write port and then pulses arm. While armed, every valid sample moves the sequencer by one step. Repetitions must fall on consecutive valid samples. A sample that breaks the pattern sends the sequencer back to the first stage, and that same sample is then tried again against the first stage. The trigger output goes high during the sample that completes the pattern. It then stays high and the sequencer stops until the next arm or reset. A disarm pulse abandons any progress without touching the trigger.

Top module: `evseq_trigger`

## Requirements
- R1: After a synchronous reset the block is disarmed, the trigger is low, the sequencer is idle, and every stage has an empty event set with both repetition bounds equal to 1, the unbounded flag clear and the final flag clear.
- R2: Stages must be satisfied in index order. The trigger output rises combinationally during the valid sample that completes the final stage.
- R3: A stage is hit when any event whose bit is set in that stage's select field is true (bit i of the select field selects event bit i). Samples that set several events are therefore accepted.
- R4: A stage counts consecutive hitting samples. The sequencer moves on to a later stage only after the count has reached the stage's lower bound. A sample that neither continues nor advances restarts the pattern, and that same sample is re-evaluated as the first sample of stage 0.
- R5: With the unbounded flag clear, a further hit on the current stage once its count equals the upper bound restarts the pattern, with the sample re-evaluated against stage 0.
- R6: With the unbounded flag set, the current stage accepts any number of consecutive hits.
- R7: When the sequencer looks forward for a later stage, it passes over any stage whose lower bound is zero, including stage 0 from the idle state.
- R8: The final stage is the lowest-numbered stage whose final flag is set, or stage 3 if no flag is set. Stages above it are never entered.
- R9: Once raised, the trigger stays high until arm or reset, and firing leaves the block disarmed.
- R10: While disarmed, valid samples have no effect. A disarm pulse discards progress. Arm clears the trigger and progress, and a sample in the same cycle as arm is ignored.
- R11: A write strobe stores the select field, lower bound, upper bound, unbounded flag and final flag into the stage given by the stage index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Pulse: clear the trigger and start watching |
| disarm_i | input | 1 | Pulse: stop watching and drop progress |
| ev_valid_i | input | 1 | Event sample is valid this cycle |
| ev_i | input | 4 | Event flags of the sample |
| cfg_we_i | input | 1 | Stage configuration write strobe |
| cfg_sel_i | input | 2 | Stage index being written |
| cfg_mask_i | input | 4 | Event select field |
| cfg_lo_i | input | 16 | Lower repetition bound |
| cfg_hi_i | input | 16 | Upper repetition bound |
| cfg_unlim_i | input | 1 | Ignore the upper bound |
| cfg_last_i | input | 1 | Mark this stage as final |
| trig_o | output | 1 | Sticky trigger |

## Verification
The trigger output is due in the same cycle as the completing sample, because it is a combinational function of the registered state and the present sample. The bench therefore places each sample on a falling edge and reads trig_o one nanosecond later, well before the rising edge that would commit the sample. State changes from arm, disarm and configuration writes take effect at the next rising edge, so each of those operations is held for a full cycle before the next sample is applied. Stickiness is checked on idle cycles that follow a firing sample.

// File: rtl/evseq_pkg.sv
package evseq_pkg;

    parameter int EV_N  = 4;
    parameter int ST_N  = 4;
    parameter int CNT_W = 16;
    localparam int SI_W = (ST_N > 1) ? $clog2(ST_N) : 1;

    // one stage of the programmed pattern
    typedef struct packed {
        logic [EV_N-1:0]  mask;
        logic [CNT_W-1:0] lo_cnt;
        logic [CNT_W-1:0] hi_cnt;
        logic             unlim;
        logic             last;
    } stage_cfg_t;

    // result of a forward search for the stage a sample lands in
    typedef struct packed {
        logic            ok;
        logic [SI_W-1:0] idx;
    } hop_t;

    // sequencer position: stage and consecutive hit count
    typedef struct packed {
        logic [SI_W-1:0]  stg;
        logic [CNT_W-1:0] cnt;
    } seq_pos_t;

    // Walk forward from 'start' up to 'fin'; the first hit wins, stages
    // with a zero lower bound may be passed over, any other miss stops.
    function automatic hop_t fwd_scan(input logic [ST_N-1:0] hit,
                                      input logic [ST_N-1:0] minz,
                                      input int              start,
                                      input int              fin);
        hop_t r;
        logic go;
        r  = '0;
        go = 1'b1;
        for (int k = 0; k < ST_N; k++) begin
            if (go && k >= start && k <= fin) begin
                if (hit[k]) begin
                    r.ok  = 1'b1;
                    r.idx = SI_W'(k);
                    go    = 1'b0;
                end else if (!minz[k]) begin
                    go = 1'b0;
                end
            end
        end
        return r;
    endfunction

    // lowest stage carrying the final flag, else the top stage
    function automatic logic [SI_W-1:0] final_stage(input logic [ST_N-1:0] flags);
        logic [SI_W-1:0] r;
        r = SI_W'(ST_N - 1);
        for (int k = ST_N - 1; k >= 0; k--) begin
            if (flags[k]) r = SI_W'(k);
        end
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + CNT_W'(1);
    endfunction

endpackage

// File: rtl/evseq_cfg_bank.sv
module evseq_cfg_bank
    import evseq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we_i,
    input  logic [SI_W-1:0]             sel_i,
    input  stage_cfg_t                  wdata_i,
    output stage_cfg_t [ST_N-1:0]       cfg_o
);

    localparam stage_cfg_t RST_CFG = '{
        mask:   '0,
        lo_cnt: CNT_W'(1),
        hi_cnt: CNT_W'(1),
        unlim:  1'b0,
        last:   1'b0
    };

    for (genvar g = 0; g < ST_N; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_o[g] <= RST_CFG;
            end else if (we_i && sel_i == SI_W'(g)) begin
                cfg_o[g] <= wdata_i;
            end
        end
    end

endmodule

// File: rtl/evseq_match.sv
module evseq_match
    import evseq_pkg::*;
(
    input  logic [EV_N-1:0]             ev_i,
    input  logic [ST_N-1:0][EV_N-1:0]   mask_i,
    output logic [ST_N-1:0]             hit_o
);

    for (genvar g = 0; g < ST_N; g++) begin : g_hit
        assign hit_o[g] = |(ev_i & mask_i[g]);
    end

endmodule

// File: rtl/evseq_engine.sv
module evseq_engine
    import evseq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        arm_i,
    input  logic                        disarm_i,
    input  logic                        ev_valid_i,
    input  logic [ST_N-1:0]             hit_i,
    input  logic [ST_N-1:0]             minz_i,
    input  logic [ST_N-1:0][CNT_W-1:0]  lo_i,
    input  logic [ST_N-1:0][CNT_W-1:0]  hi_i,
    input  logic [ST_N-1:0]             unlim_i,
    input  logic [SI_W-1:0]             fin_i,
    output logic                        armed_o,
    output logic                        trig_q_o,
    output logic                        fire_o,
    output seq_pos_t                    pos_o
);

    seq_pos_t pos_q, pos_nx;
    logic     armed_q, trig_q;
    logic     sat, room, complete;
    hop_t     adv, redo;

    assign sat  = pos_q.cnt >= lo_i[pos_q.stg];
    assign room = unlim_i[pos_q.stg] || (pos_q.cnt < hi_i[pos_q.stg]);
    assign adv  = sat ? fwd_scan(hit_i, minz_i, int'(pos_q.stg) + 1, int'(fin_i)) : '0;
    assign redo = fwd_scan(hit_i, minz_i, 0, int'(fin_i));

    // advance beats continue beats restart
    always_comb begin
        pos_nx = '0;
        if (adv.ok) begin
            pos_nx.stg = adv.idx;
            pos_nx.cnt = CNT_W'(1);
        end else if (hit_i[pos_q.stg] && room) begin
            pos_nx.stg = pos_q.stg;
            pos_nx.cnt = sat_inc(pos_q.cnt);
        end else if (redo.ok) begin
            pos_nx.stg = redo.idx;
            pos_nx.cnt = CNT_W'(1);
        end
    end

    assign complete = (pos_nx.stg == fin_i) && (pos_nx.cnt != '0)
                   && (pos_nx.cnt >= lo_i[fin_i]);
    assign fire_o   = armed_q && ev_valid_i && !arm_i && !disarm_i && complete;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            trig_q  <= 1'b0;
            pos_q   <= '0;
        end else if (arm_i) begin
            armed_q <= 1'b1;
            trig_q  <= 1'b0;
            pos_q   <= '0;
        end else if (disarm_i) begin
            armed_q <= 1'b0;
            pos_q   <= '0;
        end else if (armed_q && ev_valid_i) begin
            if (fire_o) begin
                armed_q <= 1'b0;
                trig_q  <= 1'b1;
                pos_q   <= '0;
            end else begin
                pos_q   <= pos_nx;
            end
        end
    end

    assign armed_o  = armed_q;
    assign trig_q_o = trig_q;
    assign pos_o    = pos_q;

endmodule

// File: rtl/evseq_trigger.sv
module evseq_trigger
    import evseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic              disarm_i,
    input  logic              ev_valid_i,
    input  logic [EV_N-1:0]   ev_i,
    input  logic              cfg_we_i,
    input  logic [SI_W-1:0]   cfg_sel_i,
    input  logic [EV_N-1:0]   cfg_mask_i,
    input  logic [CNT_W-1:0]  cfg_lo_i,
    input  logic [CNT_W-1:0]  cfg_hi_i,
    input  logic              cfg_unlim_i,
    input  logic              cfg_last_i,
    output logic              trig_o
);

    stage_cfg_t                 wdata;
    stage_cfg_t [ST_N-1:0]      cfg;
    logic [ST_N-1:0][EV_N-1:0]  mask_v;
    logic [ST_N-1:0][CNT_W-1:0] lo_v, hi_v;
    logic [ST_N-1:0]            unlim_v, last_v, minz_v, hit_v;
    logic [SI_W-1:0]            fin;
    logic                       armed_q, trig_q, fire;
    seq_pos_t                   pos_q;

    assign wdata = '{
        mask:   cfg_mask_i,
        lo_cnt: cfg_lo_i,
        hi_cnt: cfg_hi_i,
        unlim:  cfg_unlim_i,
        last:   cfg_last_i
    };

    evseq_cfg_bank u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we_i),
        .sel_i   (cfg_sel_i),
        .wdata_i (wdata),
        .cfg_o   (cfg)
    );

    for (genvar g = 0; g < ST_N; g++) begin : g_split
        assign mask_v[g]  = cfg[g].mask;
        assign lo_v[g]    = cfg[g].lo_cnt;
        assign hi_v[g]    = cfg[g].hi_cnt;
        assign unlim_v[g] = cfg[g].unlim;
        assign last_v[g]  = cfg[g].last;
        assign minz_v[g]  = (cfg[g].lo_cnt == '0);
    end

    assign fin = final_stage(last_v);

    evseq_match u_match (
        .ev_i   (ev_i),
        .mask_i (mask_v),
        .hit_o  (hit_v)
    );

    evseq_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .arm_i      (arm_i),
        .disarm_i   (disarm_i),
        .ev_valid_i (ev_valid_i),
        .hit_i      (hit_v),
        .minz_i     (minz_v),
        .lo_i       (lo_v),
        .hi_i       (hi_v),
        .unlim_i    (unlim_v),
        .fin_i      (fin),
        .armed_o    (armed_q),
        .trig_q_o   (trig_q),
        .fire_o     (fire),
        .pos_o      (pos_q)
    );

    assign trig_o = trig_q | fire;

endmodule

// File: rtl/evseq_trigger_chk.sv
module evseq_trigger_chk
    import evseq_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     arm_i,
    input logic     disarm_i,
    input logic     ev_valid_i,
    input logic     trig_o,
    input logic     armed_q,
    input logic     trig_q,
    input logic     fire,
    input seq_pos_t pos_q
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!armed_q && !trig_q && pos_q == '0));

    assert_fire_on_sample_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_o) |-> ev_valid_i);

    assert_hold_without_sample_R4: assert property (@(posedge clk) disable iff (rst)
        (!ev_valid_i && !arm_i && !disarm_i) |=> $stable(pos_q));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (trig_o && !arm_i) |=> trig_o);

    assert_fire_disarms_R9: assert property (@(posedge clk) disable iff (rst)
        fire |=> (trig_q && !armed_q));

    assert_arm_clears_R10: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (armed_q && !trig_q && pos_q == '0));

    assert_ignore_disarmed_R10: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !arm_i) |=> $stable(pos_q));

endmodule

bind evseq_trigger evseq_trigger_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .arm_i      (arm_i),
    .disarm_i   (disarm_i),
    .ev_valid_i (ev_valid_i),
    .trig_o     (trig_o),
    .armed_q    (armed_q),
    .trig_q     (trig_q),
    .fire       (fire),
    .pos_q      (pos_q)
);

// File: tb/tb_evseq_trigger.sv
module tb_evseq_trigger;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arm_i = 1'b0;
    logic        disarm_i = 1'b0;
    logic        ev_valid_i = 1'b0;
    logic [3:0]  ev_i = '0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_sel_i = '0;
    logic [3:0]  cfg_mask_i = '0;
    logic [15:0] cfg_lo_i = '0;
    logic [15:0] cfg_hi_i = '0;
    logic        cfg_unlim_i = 1'b0;
    logic        cfg_last_i = 1'b0;
    logic        trig_o;

    int nvec = 0;
    int nbad = 0;

    always #2 clk = ~clk;

    evseq_trigger dut (
        .clk(clk), .rst(rst), .arm_i(arm_i), .disarm_i(disarm_i),
        .ev_valid_i(ev_valid_i), .ev_i(ev_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_mask_i(cfg_mask_i),
        .cfg_lo_i(cfg_lo_i), .cfg_hi_i(cfg_hi_i), .cfg_unlim_i(cfg_unlim_i),
        .cfg_last_i(cfg_last_i), .trig_o(trig_o)
    );

    task automatic check(input logic act, input logic exp, input string req);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: trig_o=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_stage(input int s, input logic [3:0] m, input int lo,
                            input int hi, input logic un, input logic la);
        @(negedge clk);
        ev_valid_i = 1'b0;
        cfg_we_i = 1'b1; cfg_sel_i = 2'(s); cfg_mask_i = m;
        cfg_lo_i = 16'(lo); cfg_hi_i = 16'(hi); cfg_unlim_i = un; cfg_last_i = la;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic arm(input string req);
        @(negedge clk);
        ev_valid_i = 1'b0; arm_i = 1'b1;
        @(negedge clk);
        arm_i = 1'b0;
        #1 check(trig_o, 1'b0, req);
    endtask

    task automatic smp(input logic [3:0] e, input logic exp, input string req);
        @(negedge clk);
        ev_valid_i = 1'b1; ev_i = e;
        #1 check(trig_o, exp, req);
    endtask

    task automatic idle(input logic exp, input string req);
        @(negedge clk);
        ev_valid_i = 1'b0; ev_i = '0;
        #1 check(trig_o, exp, req);
    endtask

    // E0 then E1 then E2, one sample each
    task automatic cfg_chain3();
        wr_stage(0, 4'b0001, 1, 1, 1'b0, 1'b0);
        wr_stage(1, 4'b0010, 1, 1, 1'b0, 1'b0);
        wr_stage(2, 4'b0100, 1, 1, 1'b0, 1'b1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1 check(trig_o, 1'b0, "R1 reset low");
        // default masks are empty: all events on while armed must not fire
        arm("R1 arm");
        smp(4'b1111, 1'b0, "R1 empty default masks");
        smp(4'b1111, 1'b0, "R1 empty default masks");
        idle(1'b0, "R1");
        @(negedge clk); disarm_i = 1'b1;
        @(negedge clk); disarm_i = 1'b0;
    endtask

    task automatic t_disarmed();
        cfg_chain3();
        smp(4'b0001, 1'b0, "R10 disarmed");
        smp(4'b0010, 1'b0, "R10 disarmed");
        smp(4'b0100, 1'b0, "R10 disarmed ignores pattern");
        idle(1'b0, "R10");
    endtask

    task automatic t_concat();
        arm("R11 R2 arm");
        smp(4'b0001, 1'b0, "R2 step0");
        smp(4'b0010, 1'b0, "R2 step1");
        smp(4'b0100, 1'b1, "R2 fires on completing sample");
        idle(1'b1, "R9 sticky");
        idle(1'b1, "R9 sticky");
        smp(4'b0001, 1'b1, "R9 sticky after more samples");
        idle(1'b1, "R9");
        arm("R10 arm clears trigger");
        // wrong order, then recovery
        smp(4'b0010, 1'b0, "R2 order");
        smp(4'b0001, 1'b0, "R2 order");
        smp(4'b0100, 1'b0, "R2 out of order no fire");
        smp(4'b0001, 1'b0, "R4 restart");
        smp(4'b0010, 1'b0, "R4 restart");
        smp(4'b0100, 1'b1, "R4 fires after restart");
        idle(1'b1, "R9");
    endtask

    task automatic t_disarm_mid();
        arm("R10 arm");
        smp(4'b0001, 1'b0, "R10 progress");
        idle(1'b0, "R10");
        @(negedge clk); disarm_i = 1'b1;
        @(negedge clk); disarm_i = 1'b0;
        smp(4'b0010, 1'b0, "R10 after disarm");
        smp(4'b0100, 1'b0, "R10 after disarm");
        arm("R10 rearm");
        smp(4'b0010, 1'b0, "R10 progress discarded");
        smp(4'b0100, 1'b0, "R10 progress discarded");
        smp(4'b0001, 1'b0, "R10");
        smp(4'b0010, 1'b0, "R10");
        smp(4'b0100, 1'b1, "R10 full pattern fires");
        idle(1'b1, "R9");
        // sample concurrent with arm is ignored
        @(negedge clk); arm_i = 1'b1; ev_valid_i = 1'b1; ev_i = 4'b0001;
        @(negedge clk); arm_i = 1'b0; ev_valid_i = 1'b0;
        smp(4'b0010, 1'b0, "R10 sample with arm ignored");
        smp(4'b0100, 1'b0, "R10 sample with arm ignored");
    endtask

    task automatic t_alternation();
        wr_stage(0, 4'b0011, 1, 1, 1'b0, 1'b0);
        wr_stage(1, 4'b1100, 1, 1, 1'b0, 1'b1);
        arm("R3 arm");
        smp(4'b0010, 1'b0, "R3 E1");
        smp(4'b0100, 1'b1, "R3 E1 then E2");
        arm("R3 arm");
        smp(4'b0001, 1'b0, "R3 E0");
        smp(4'b1000, 1'b1, "R3 E0 then E3");
        arm("R3 arm");
        smp(4'b0101, 1'b0, "R3 multi-bit");
        smp(4'b1010, 1'b1, "R3 multi-bit samples");
        arm("R5 arm");
        smp(4'b0001, 1'b0, "R5 first");
        smp(4'b0001, 1'b0, "R5 over max re-evaluates");
        smp(4'b1000, 1'b1, "R5 re-evaluated sample counts");
    endtask

    task automatic t_exact();
        wr_stage(0, 4'b0001, 3, 3, 1'b0, 1'b0);
        wr_stage(1, 4'b0010, 1, 1, 1'b0, 1'b1);
        arm("R4 arm");
        smp(4'b0001, 1'b0, "R4");
        smp(4'b0001, 1'b0, "R4");
        smp(4'b0010, 1'b0, "R4 below min");
        for (int i = 0; i < 3; i++) smp(4'b0001, 1'b0, "R4 count");
        smp(4'b0010, 1'b1, "R4 exact count fires");
        arm("R5 arm");
        for (int i = 0; i < 4; i++) smp(4'b0001, 1'b0, "R5 count");
        smp(4'b0010, 1'b0, "R5 above max no fire");
        for (int i = 0; i < 3; i++) smp(4'b0001, 1'b0, "R5 count");
        smp(4'b0010, 1'b1, "R5 fires after recovery");
    endtask

    task automatic t_range();
        wr_stage(0, 4'b0001, 2, 3, 1'b0, 1'b0);
        arm("R4 arm");
        smp(4'b0001, 1'b0, "R4 range");
        smp(4'b0010, 1'b0, "R4 range below");
        smp(4'b0001, 1'b0, "R4 range");
        smp(4'b0001, 1'b0, "R4 range");
        smp(4'b0010, 1'b1, "R4 range lower bound fires");
    endtask

    task automatic t_unlimited();
        wr_stage(0, 4'b0001, 1, 1, 1'b1, 1'b0);
        arm("R6 arm");
        for (int i = 0; i < 20; i++) smp(4'b0001, 1'b0, "R6 long run");
        smp(4'b0010, 1'b1, "R6 unbounded fires");
    endtask

    task automatic t_skip();
        wr_stage(0, 4'b0001, 1, 1, 1'b0, 1'b0);
        wr_stage(1, 4'b0010, 0, 1, 1'b0, 1'b0);
        wr_stage(2, 4'b0100, 1, 1, 1'b0, 1'b1);
        arm("R7 arm");
        smp(4'b0001, 1'b0, "R7");
        smp(4'b0100, 1'b1, "R7 optional stage skipped");
        arm("R7 arm");
        smp(4'b0001, 1'b0, "R7");
        smp(4'b0010, 1'b0, "R7");
        smp(4'b0100, 1'b1, "R7 optional stage taken");
        arm("R7 arm");
        smp(4'b0001, 1'b0, "R7");
        smp(4'b0010, 1'b0, "R7");
        smp(4'b0010, 1'b0, "R7 optional over max");
        smp(4'b0100, 1'b0, "R7 no fire after break");
        // zero lower bound on stage 0
        wr_stage(0, 4'b1000, 0, 1, 1'b1, 1'b0);
        wr_stage(1, 4'b0010, 1, 1, 1'b0, 1'b1);
        arm("R7 arm");
        smp(4'b0010, 1'b1, "R7 stage 0 skipped from idle");
    endtask

    task automatic t_final();
        wr_stage(0, 4'b0001, 1, 1, 1'b0, 1'b0);
        wr_stage(1, 4'b0010, 1, 1, 1'b0, 1'b1);
        wr_stage(2, 4'b0100, 1, 1, 1'b0, 1'b0);
        wr_stage(3, 4'b1000, 1, 1, 1'b0, 1'b1);
        arm("R8 arm");
        smp(4'b0001, 1'b0, "R8");
        smp(4'b0010, 1'b1, "R8 lowest final flag ends pattern");
        wr_stage(1, 4'b0010, 1, 1, 1'b0, 1'b0);
        wr_stage(3, 4'b1000, 1, 1, 1'b0, 1'b0);
        arm("R8 arm");
        smp(4'b0001, 1'b0, "R8");
        smp(4'b0010, 1'b0, "R8");
        smp(4'b0100, 1'b0, "R8 top stage is final");
        smp(4'b1000, 1'b1, "R8 top stage is final");
    endtask

    initial begin
        #200000;
        nbad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_disarmed();
        t_concat();
        t_disarm_mid();
        t_alternation();
        t_exact();
        t_range();
        t_unlimited();
        t_skip();
        t_final();
        idle(1'b1, "R9 end");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule